// File: doc/BRIEF.md
# Waveform Persistence Bitmap Mapper

This block plots a stream of 8-bit amplitude samples into a one-bit-per-pixel bitmap held in an external dual-port RAM. Time runs along the horizontal axis and amplitude along the vertical axis. The grid is 128 columns by 64 rows, and each RAM bit is exactly one display pixel. Within a capture, the column of a sample is its position in that capture. The row is the upper six bits of the amplitude. There is no intensity or depth grading.

Each plotted point is a read-modify-write of one byte. The byte is read, the pixel bit is OR-ed in, and the byte is written back. Points from successive captures therefore pile up in the same bitmap, and repeated waveforms show overlaid. A clear command zeroes the whole bitmap before a fresh overlay starts. Read and write use separate RAM ports, so the read for one point can go out in the same cycle as the write of the previous point. When both points fall in the same byte, an internal forwarding path supplies the byte that is being written.

The controller has five states:
- `ST_IDLE` waits for a sample or a clear.
- `ST_MERGE` receives the read byte and ORs in the pixel.
- `ST_WRITE` writes the merged byte back and may accept the next sample.
- `ST_CLEAR` writes zero to one address per cycle.
- `ST_DONE` signals the end of a clear.

The transitions are:
- IDLE→MERGE on a plotted sample.
- IDLE→CLEAR on a pending clear.
- MERGE→WRITE always.
- WRITE→CLEAR on a pending clear.
- WRITE→MERGE on a plotted sample.
- WRITE→IDLE otherwise.
- CLEAR→CLEAR until the last address.
- CLEAR→DONE at the last address.
- DONE→IDLE always.

Top module: `wave_bitmap_plotter`

## Requirements
- R1: While and after synchronous active-high reset, the block is idle. `smp_ready` is 1, `clr_done`, `ram_rd_en` and `ram_wr_en` are 0, and the column counter is 0, so the first sample after reset lands in column 0.
- R2: A sample with amplitude `a` in column `c` maps to pixel index `{a[7:2], c[6:0]}`. Its byte address is `{a[7:2], c[6:3]}` and its bit is `7 - c[2:0]`, so column 0 of a byte is the MSB and the mask is `8'h80 >> c[2:0]`.
- R3: The byte written for a point equals the byte's previous content OR the point's mask. Points from earlier samples and captures are never erased by plotting.
- R4: A plotted sample raises `ram_rd_en` with its byte address in the cycle it is accepted. `smp_ready` is 0 in the next cycle (merge). `ram_wr_en` carries the merged byte in the cycle after that. A new sample may be accepted in that write cycle.
- R5: When a sample is accepted during the write cycle of a point in the same byte, the merge uses the byte being written, not the stale RAM read.
- R6: `cap_start` sets the column counter to 0. A sample accepted in the same cycle as `cap_start` takes column 0, and each plotted sample advances the column by one.
- R7: After 128 samples in a capture, further samples are still accepted but produce no RAM read or write, until the next `cap_start`.
- R8: A clear writes 0x00 to byte addresses 0 to 1023 in ascending order, one per cycle. `clr_done` is then high for exactly one cycle, and `smp_ready` returns in the following cycle.
- R9: During a clear, `smp_ready` is 0 and no sample is taken. A `clr_req` arriving while a clear runs has no effect.
- R10: A `clr_req` arriving while a point is in flight lets that point finish its write before the first clear write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample present on `smp_data` |
| smp_data | input | 8 | Sample amplitude |
| smp_ready | output | 1 | Block can accept a sample this cycle |
| cap_start | input | 1 | Start of a new capture, column back to 0 |
| clr_req | input | 1 | Request to erase the whole bitmap |
| clr_done | output | 1 | One-cycle pulse at the end of a clear |
| ram_rd_en | output | 1 | RAM read strobe, data expected next cycle |
| ram_rd_addr | output | 10 | RAM read byte address |
| ram_rd_data | input | 8 | RAM read data, one cycle after the strobe |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_wr_addr | output | 10 | RAM write byte address |
| ram_wr_data | output | 8 | RAM write data |

## Verification
A faulty column count or row slice shows up on `ram_wr_addr` and in the mask bits of the very first write after the bad sample, two cycles after acceptance. A lost forwarding decision or a stale merge register drops an earlier pixel from the byte written by the second point of a back-to-back pair, so it is visible within four cycles. State errors in the clear sequence surface as a missing, extra or out-of-order zero write. They can also show as a `clr_done` pulse with the wrong timing, or as a sample accepted while `smp_ready` should be low. Each of these is visible on the RAM write port within one cycle of the fault.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MERGE,
        ST_WRITE,
        ST_CLEAR,
        ST_DONE
    } wbm_state_t;

endpackage

// File: rtl/wbm_column_ctr.sv
module wbm_column_ctr #(
    parameter int COL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             advance,
    output logic [COL_W-1:0] col,
    output logic             room
);
    localparam int COLS = 1 << COL_W;

    // one extra bit marks "capture full"
    logic [COL_W:0] cnt;

    assign col  = restart ? '0 : cnt[COL_W-1:0];
    assign room = restart | ~cnt[COL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= advance ? (COL_W+1)'(1) : '0;
        end else if (advance) begin
            cnt <= cnt + 1'b1;
        end
    end

    // the counter never passes the saturation value
    assert_col_saturates_R7: assert property (@(posedge clk) disable iff (rst)
        cnt <= (COL_W+1)'(COLS));

    // a full counter only moves again through restart
    assert_full_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt[COL_W] && !restart) |=> cnt[COL_W]);

endmodule

// File: rtl/wbm_pixel_locate.sv
module wbm_pixel_locate #(
    parameter int COL_W = 7,
    parameter int ROW_W = 6,
    parameter int AMP_W = 8
) (
    input  logic [AMP_W-1:0]           amp,
    input  logic [COL_W-1:0]           col,
    output logic [COL_W+ROW_W-4:0]     byte_addr,
    output logic [7:0]                 bit_mask
);
    localparam int PIX_W = COL_W + ROW_W;

    logic [ROW_W-1:0] row;
    logic [PIX_W-1:0] pix;

    assign row       = amp[AMP_W-1 -: ROW_W];
    assign pix       = {row, col};
    assign byte_addr = pix[PIX_W-1:3];

    // first pixel of a byte sits in the MSB
    for (genvar b = 0; b < 8; b++) begin : g_mask
        assign bit_mask[b] = (pix[2:0] == 3'(7 - b));
    end

    always_comb begin
        assert_mask_onehot_R2: assert ($onehot(bit_mask));
    end

endmodule

// File: rtl/wbm_clear_walker.sv
module wbm_clear_walker #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    output logic [ADDR_W-1:0] idx,
    output logic              last
);
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            idx <= '0;
        end else begin
            idx <= idx + 1'b1;
        end
    end

    assign last = run && (idx == {ADDR_W{1'b1}});

    // addresses climb by one each cycle of a running clear
    assert_walk_ascends_R8: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> (idx == ADDR_W'($past(idx) + 1'b1)));

endmodule

// File: rtl/wave_bitmap_plotter.sv
module wave_bitmap_plotter
    import wbm_pkg::*;
#(
    parameter int COL_W = 7,
    parameter int ROW_W = 6,
    parameter int AMP_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         smp_valid,
    input  logic [AMP_W-1:0]             smp_data,
    output logic                         smp_ready,
    input  logic                         cap_start,
    input  logic                         clr_req,
    output logic                         clr_done,
    output logic                         ram_rd_en,
    output logic [COL_W+ROW_W-4:0]       ram_rd_addr,
    input  logic [7:0]                   ram_rd_data,
    output logic                         ram_wr_en,
    output logic [COL_W+ROW_W-4:0]       ram_wr_addr,
    output logic [7:0]                   ram_wr_data
);
    localparam int PIX_W  = COL_W + ROW_W;
    localparam int ADDR_W = PIX_W - 3;

    wbm_state_t        state, state_nx;
    logic              clr_pend;
    logic              accept, plot, room;
    logic [COL_W-1:0]  col;
    logic [ADDR_W-1:0] loc_addr, p_addr, w_addr, clr_idx;
    logic [7:0]        loc_mask, p_mask, m_data, merge_base;
    logic              fwd, clr_last;

    assign smp_ready = (state == ST_IDLE || state == ST_WRITE) && !clr_pend;
    assign accept    = smp_valid && smp_ready;
    assign plot      = accept && room;

    wbm_column_ctr #(.COL_W(COL_W)) u_col (
        .clk     (clk),
        .rst     (rst),
        .restart (cap_start),
        .advance (plot),
        .col     (col),
        .room    (room)
    );

    wbm_pixel_locate #(.COL_W(COL_W), .ROW_W(ROW_W), .AMP_W(AMP_W)) u_loc (
        .amp       (smp_data),
        .col       (col),
        .byte_addr (loc_addr),
        .bit_mask  (loc_mask)
    );

    wbm_clear_walker #(.ADDR_W(ADDR_W)) u_walk (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_CLEAR),
        .idx  (clr_idx),
        .last (clr_last)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (clr_pend) state_nx = ST_CLEAR;
                      else if (plot) state_nx = ST_MERGE;
            ST_MERGE: state_nx = ST_WRITE;
            ST_WRITE: if (clr_pend) state_nx = ST_CLEAR;
                      else if (plot) state_nx = ST_MERGE;
                      else state_nx = ST_IDLE;
            ST_CLEAR: if (clr_last) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // clear request capture; requests during a running clear are dropped
    always_ff @(posedge clk) begin
        if (rst) begin
            clr_pend <= 1'b0;
        end else if (state == ST_CLEAR || state == ST_DONE || state_nx == ST_CLEAR) begin
            clr_pend <= 1'b0;
        end else if (clr_req) begin
            clr_pend <= 1'b1;
        end
    end

    // read-modify-write datapath with same-byte forwarding
    assign merge_base = (fwd && p_addr == w_addr) ? m_data : ram_rd_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_addr <= '0;
            p_mask <= '0;
            fwd    <= 1'b0;
            w_addr <= '0;
            m_data <= '0;
        end else begin
            if (plot) begin
                p_addr <= loc_addr;
                p_mask <= loc_mask;
                fwd    <= (state == ST_WRITE);
            end
            if (state == ST_MERGE) begin
                w_addr <= p_addr;
                m_data <= merge_base | p_mask;
            end
        end
    end

    // outputs
    always_comb begin
        ram_rd_en   = plot;
        ram_rd_addr = loc_addr;
        ram_wr_en   = 1'b0;
        ram_wr_addr = w_addr;
        ram_wr_data = m_data;
        clr_done    = 1'b0;
        unique case (state)
            ST_WRITE: ram_wr_en = 1'b1;
            ST_CLEAR: begin
                ram_wr_en   = 1'b1;
                ram_wr_addr = clr_idx;
                ram_wr_data = '0;
            end
            ST_DONE:  clr_done = 1'b1;
            default:  ;
        endcase
    end

    // a plotted sample blocks the next cycle
    assert_ready_drops_R4: assert property (@(posedge clk) disable iff (rst)
        plot |=> !smp_ready);

    // write-back to the same byte two cycles after the read
    assert_write_follows_read_R4: assert property (@(posedge clk) disable iff (rst)
        ram_rd_en |-> ##2 (ram_wr_en && ram_wr_addr == $past(ram_rd_addr, 2)));

    // merged byte always contains the pixel that was read for
    assert_bit_kept_R3: assert property (@(posedge clk) disable iff (rst)
        ram_rd_en |-> ##2 ((ram_wr_data & $past(loc_mask, 2)) == $past(loc_mask, 2)));

    // forwarded merge keeps the bits of the byte just written
    assert_forward_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        (ram_wr_en && ram_rd_en && ram_rd_addr == ram_wr_addr && state == ST_WRITE)
        |-> ##2 ((ram_wr_data & $past(ram_wr_data, 2)) == $past(ram_wr_data, 2)));

    // done pulse lasts one cycle and follows the top address write
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        clr_done |=> !clr_done);
    assert_done_after_top_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(clr_done) |-> $past(ram_wr_en && ram_wr_addr == {ADDR_W{1'b1}}));

    // nothing is read or accepted while clearing
    assert_no_sample_in_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CLEAR) |-> (!ram_rd_en && !smp_ready));

endmodule

// File: tb/wave_bitmap_plotter_bench.sv
module wave_bitmap_plotter_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_data = '0;
    logic       smp_ready;
    logic       cap_start = 1'b0;
    logic       clr_req = 1'b0;
    logic       clr_done;
    logic       ram_rd_en;
    logic [9:0] ram_rd_addr;
    logic [7:0] ram_rd_data;
    logic       ram_wr_en;
    logic [9:0] ram_wr_addr;
    logic [7:0] ram_wr_data;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mem   [1024];
    logic [7:0] model [1024];
    int         col_m = 0;
    int         exp_addr_q [$];
    int         exp_data_q [$];

    always #5 clk = ~clk;

    wave_bitmap_plotter u_wave_bitmap_plotter (
        .clk         (clk),
        .rst         (rst),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .smp_ready   (smp_ready),
        .cap_start   (cap_start),
        .clr_req     (clr_req),
        .clr_done    (clr_done),
        .ram_rd_en   (ram_rd_en),
        .ram_rd_addr (ram_rd_addr),
        .ram_rd_data (ram_rd_data),
        .ram_wr_en   (ram_wr_en),
        .ram_wr_addr (ram_wr_addr),
        .ram_wr_data (ram_wr_data)
    );

    // RAM model: the read returns the old content on a same-cycle write
    always @(posedge clk) begin
        if (ram_rd_en) ram_rd_data <= mem[ram_rd_addr];
        if (ram_wr_en) mem[ram_wr_addr] <= ram_wr_data;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: every RAM write is compared against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && ram_wr_en) begin
            if (exp_addr_q.size() == 0) begin
                check(1'b0, "R3/R7/R9 unexpected write", int'(ram_wr_addr), -1);
            end else begin
                int ea, ed;
                ea = exp_addr_q.pop_front();
                ed = exp_data_q.pop_front();
                check(ram_wr_addr == 10'(ea), "R2/R8 write address", int'(ram_wr_addr), ea);
                check(ram_wr_data == 8'(ed), "R3/R5/R8 write data", int'(ram_wr_data), ed);
            end
        end
    end

    // driver: present one sample, wait for acceptance, update the model
    task automatic send(input logic [7:0] amp, input bit start);
        int c, a;
        bit will_plot;
        smp_valid = 1'b1;
        smp_data  = amp;
        cap_start = start;
        c = start ? 0 : col_m;
        will_plot = (c < 128);
        forever begin
            #1;
            if (smp_ready) break;
            @(negedge clk);
        end
        check(ram_rd_en == will_plot, "R4/R7 read strobe on accept", int'(ram_rd_en), int'(will_plot));
        @(posedge clk);
        if (will_plot) begin
            a = int'(amp[7:2]) * 16 + c / 8;
            model[a] = model[a] | (8'h80 >> (c % 8));
            exp_addr_q.push_back(a);
            exp_data_q.push_back(int'(model[a]));
            col_m = c + 1;
        end else begin
            col_m = c;
        end
        @(negedge clk);
        cap_start = 1'b0;
        if (will_plot) check(smp_ready == 1'b0, "R4 ready low in merge", int'(smp_ready), 0);
    endtask

    task automatic idle(input int n);
        smp_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_clear(input bit poke);
        int guard;
        clr_req = 1'b1;
        for (int i = 0; i < 1024; i++) begin
            exp_addr_q.push_back(i);
            exp_data_q.push_back(0);
            model[i] = 8'h00;
        end
        @(negedge clk);
        clr_req = 1'b0;
        if (poke) begin
            smp_valid = 1'b1;
            smp_data  = 8'h55;
            repeat (5) @(negedge clk);
            check(smp_ready == 1'b0, "R9 ready low during clear", int'(smp_ready), 0);
            clr_req = 1'b1;
            @(negedge clk);
            clr_req = 1'b0;
        end
        guard = 0;
        while (!clr_done && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        smp_valid = 1'b0;
        check(clr_done == 1'b1, "R8 done pulse seen", int'(clr_done), 1);
        check(exp_addr_q.size() == 0, "R8 all zero writes before done", exp_addr_q.size(), 0);
        @(negedge clk);
        check(clr_done == 1'b0, "R8 done lasts one cycle", int'(clr_done), 0);
        check(smp_ready == 1'b1, "R8 ready back after done", int'(smp_ready), 1);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i]   = 8'h00;
            model[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(smp_ready == 1'b1, "R1 ready in reset", int'(smp_ready), 1);
        check(clr_done == 1'b0, "R1 done low", int'(clr_done), 0);
        check(ram_wr_en == 1'b0, "R1 no write", int'(ram_wr_en), 0);
        rst = 1'b0;
        @(negedge clk);
        check(ram_rd_en == 1'b0, "R1 no read when idle", int'(ram_rd_en), 0);

        // R1/R2: first sample after reset, no start, column 0, row 39
        send(8'h9C, 1'b0);
        idle(4);
        check(mem[624] == 8'h80, "R1/R2 first pixel MSB of byte 624", int'(mem[624]), 8'h80);

        // R6/R2: ramp capture across several rows
        for (int i = 0; i < 20; i++) send(8'(i * 13), (i == 0));
        idle(4);

        // R5: back-to-back samples in one byte
        send(8'hF0, 1'b1);
        for (int i = 1; i < 8; i++) send(8'hF0, 1'b0);
        idle(4);
        check(mem[60 * 16] == 8'hFF, "R5 forwarded byte full", int'(mem[960]), 8'hFF);

        // R3: second capture overlays, shifted pattern
        for (int i = 0; i < 24; i++) send(8'(i * 13 + 4), (i == 0));
        for (int i = 0; i < 16; i++) send(8'hF3, (i == 0));
        idle(4);
        check(mem[960] == 8'hFF && mem[961] == 8'hFF, "R3 overlay kept", int'(mem[961]), 8'hFF);

        // R7: saturation after 128 samples
        for (int i = 0; i < 132; i++) send(8'(i * 2), (i == 0));
        idle(6);
        check(exp_addr_q.size() == 0, "R7 no pending writes", exp_addr_q.size(), 0);
        send(8'h10, 1'b1);
        idle(4);

        // R10: clear while a point is in flight
        send(8'h44, 1'b0);
        do_clear(1'b0);
        check(mem[17 * 16] == 8'h00 && mem[624] == 8'h00, "R10/R8 bitmap cleared", int'(mem[272]), 0);

        // R8/R9: clear with samples offered and a second request
        send(8'hAA, 1'b1);
        idle(3);
        do_clear(1'b1);
        idle(4);

        // after clear a point lands on an empty byte
        send(8'h27, 1'b1);
        send(8'h27, 1'b0);
        idle(5);
        check(mem[9 * 16] == 8'hC0, "R8/R3 fresh byte after clear", int'(mem[144]), 8'hC0);

        // whole-bitmap comparison
        begin
            int bad = 0;
            for (int i = 0; i < 1024; i++) if (mem[i] !== model[i]) bad++;
            check(bad == 0, "R3 bitmap matches model", bad, 0);
        end
        check(exp_addr_q.size() == 0, "R4 scoreboard drained", exp_addr_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule